// File: doc/BRIEF.md
# Peripheral Module Power-State Sequencer

This block holds the clock and local reset of a set of peripheral modules, up to 32 of them. Software picks a wanted state for each module by writing that module's control register. The write only records the request. Nothing moves until software writes the global start command. At that point every module whose request is a valid state and differs from its present state starts its own sequence.

A global busy bit stays set until the last module has finished. Software polls this bit until it reads zero. It can then read each module's present state from a read-only status register.

Each sequence has three steps of `STEP_CYC` cycles each. The steps are ordered so that a module's reset is only released while its clock runs, and its clock is only stopped after any wanted reset has already been applied.

Top module: `pwr_mod_ctrl`

## Requirements
- R1: After reset, every module has its clock enable at 0 and its reset at 1. Every control register, every status register and the busy bit read 0.
- R2: Module n's control register is at byte address 0xA00 + 4*n. A write stores bits 4:0 of the write data as the wanted state. Bits 31:5 always read 0, and a write cannot change them.
- R3: Writing a control register changes no module output, no present state and no busy bit.
- R4: A write with bit 0 set to the command register at 0x120 starts a transition in every module whose stored wanted state is 0 to 3 and differs from its present state. Every other module is left untouched.
- R5: State codes are as follows. 0 means clock stopped with reset asserted. 1 means clock running with reset asserted. 2 means clock stopped with reset released. 3 means clock running with reset released. The clock enable equals bit 0 of the code, and the reset equals the inverse of bit 1.
- R6: Take the command edge as cycle 0. At that edge the clock enable is set to 1 if the target clock runs or the reset level must change; otherwise it is held. At edge STEP_CYC the reset takes its target level. At edge 2*STEP_CYC the clock enable takes its target level. At edge 3*STEP_CYC the present state becomes the target.
- R7: Bit 0 of the busy register at 0x128 reads 1 while any module is in a transition. It reads 0 from edge 3*STEP_CYC after the accepted command onward.
- R8: A start command written while the busy bit is 1 is ignored. A wanted state written at that time waits for the next accepted command.
- R9: Module n's status register at 0xA00 - 0x200 + 4*n, i.e. 0x800 + 4*n, returns the present state in bits 4:0. Bits 31:5 read 0.
- R10: A wanted state of 4 or more starts no transition. The module's outputs and present state stay as they were, and the busy bit stays 0.
- R11: The command register and every unmapped address read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, decoded from reg_addr combinationally |
| mod_clk_en | output | N_MODS | Clock enable, one bit per module |
| mod_rst | output | N_MODS | Local reset, one bit per module, active high |

## Verification
The bound checker runs on every cycle and covers three ordering rules. First, a reset is never released while that module's clock is stopped. Second, a clock never stops together with a reset that was not already asserted. Third, clock and reset only move while the busy bit is set. The checker also holds that, whenever the block is idle, each module's outputs agree with its reported present state.

Three things need the bench's scenarios instead: the exact cycle of each step, the rejection of a start command issued mid-transition, and the handling of invalid wanted states. The bench sweeps all sixteen from/to state pairs and predicts the clock and reset level at every cycle of each sequence.

// File: rtl/pwr_mod_pkg.sv
package pwr_mod_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int ST_W   = 5;

    localparam logic [ADDR_W-1:0] CMD_ADDR  = 12'h120;
    localparam logic [ADDR_W-1:0] BUSY_ADDR = 12'h128;
    localparam logic [ADDR_W-1:0] CUR_BASE  = 12'h800;
    localparam logic [ADDR_W-1:0] CTRL_BASE = 12'hA00;

    typedef logic [ST_W-1:0] mod_state_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAKE,
        SEQ_RESET,
        SEQ_CLOCK
    } seq_phase_t;

    function automatic logic st_clk(input mod_state_t s);
        return s[0];
    endfunction

    function automatic logic st_rst(input mod_state_t s);
        return ~s[1];
    endfunction

    function automatic logic st_valid(input mod_state_t s);
        return s < mod_state_t'(4);
    endfunction

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int idx);
        return CTRL_BASE + ADDR_W'(4 * idx);
    endfunction

    function automatic logic [ADDR_W-1:0] cur_addr(input int idx);
        return CUR_BASE + ADDR_W'(4 * idx);
    endfunction

endpackage

// File: rtl/pwr_mod_seq.sv
module pwr_mod_seq
    import pwr_mod_pkg::*;
#(
    parameter int STEP_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  mod_state_t want,
    output logic       clk_en,
    output logic       lrst,
    output mod_state_t cur,
    output logic       active
);
    localparam int CW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(STEP_CYC - 1);

    seq_phase_t phase_q;
    logic [CW-1:0] cnt_q;
    mod_state_t tgt_q;
    mod_state_t cur_q;
    logic clk_q;
    logic rst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= SEQ_IDLE;
            cnt_q   <= '0;
            tgt_q   <= '0;
            cur_q   <= '0;
            clk_q   <= 1'b0;
            rst_q   <= 1'b1;
        end else begin
            unique case (phase_q)
                SEQ_IDLE: begin
                    if (start && st_valid(want) && (want != cur_q)) begin
                        tgt_q   <= want;
                        phase_q <= SEQ_WAKE;
                        cnt_q   <= CNT_LOAD;
                        if (st_clk(want) || (st_rst(want) != rst_q))
                            clk_q <= 1'b1;
                    end
                end
                SEQ_WAKE: begin
                    if (cnt_q == '0) begin
                        phase_q <= SEQ_RESET;
                        cnt_q   <= CNT_LOAD;
                        rst_q   <= st_rst(tgt_q);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SEQ_RESET: begin
                    if (cnt_q == '0) begin
                        phase_q <= SEQ_CLOCK;
                        cnt_q   <= CNT_LOAD;
                        clk_q   <= st_clk(tgt_q);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                SEQ_CLOCK: begin
                    if (cnt_q == '0) begin
                        phase_q <= SEQ_IDLE;
                        cur_q   <= tgt_q;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: phase_q <= SEQ_IDLE;
            endcase
        end
    end

    assign clk_en = clk_q;
    assign lrst   = rst_q;
    assign cur    = cur_q;
    assign active = (phase_q != SEQ_IDLE);

endmodule

// File: rtl/pwr_mod_regs.sv
module pwr_mod_regs
    import pwr_mod_pkg::*;
#(
    parameter int N_MODS = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          busy,
    input  logic [N_MODS-1:0][ST_W-1:0]   cur_all,
    output logic [N_MODS-1:0][ST_W-1:0]   want_all,
    output logic                          go,
    output logic [DATA_W-1:0]             rdata
);
    logic [N_MODS-1:0][ST_W-1:0] want_q;

    for (genvar gi = 0; gi < N_MODS; gi++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                want_q[gi] <= '0;
            else if (we && (addr == ctrl_addr(gi)))
                want_q[gi] <= wdata[ST_W-1:0];
        end
    end

    assign go       = we && (addr == CMD_ADDR) && wdata[0] && !busy;
    assign want_all = want_q;

    always_comb begin
        rdata = '0;
        if (addr == BUSY_ADDR)
            rdata[0] = busy;
        for (int i = 0; i < N_MODS; i++) begin
            if (addr == ctrl_addr(i))
                rdata[ST_W-1:0] = want_q[i];
            if (addr == cur_addr(i))
                rdata[ST_W-1:0] = cur_all[i];
        end
    end

endmodule

// File: rtl/pwr_mod_ctrl.sv
module pwr_mod_ctrl
    import pwr_mod_pkg::*;
#(
    parameter int N_MODS   = 32,
    parameter int STEP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [N_MODS-1:0] mod_clk_en,
    output logic [N_MODS-1:0] mod_rst
);
    logic [N_MODS-1:0][ST_W-1:0] want_all;
    logic [N_MODS-1:0][ST_W-1:0] cur_all;
    logic [N_MODS-1:0]           active;
    logic                        go;
    logic                        xfer_busy;

    assign xfer_busy = |active;

    pwr_mod_regs #(.N_MODS(N_MODS)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (reg_we),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .busy     (xfer_busy),
        .cur_all  (cur_all),
        .want_all (want_all),
        .go       (go),
        .rdata    (reg_rdata)
    );

    for (genvar gm = 0; gm < N_MODS; gm++) begin : g_mod
        pwr_mod_seq #(.STEP_CYC(STEP_CYC)) u_seq (
            .clk    (clk),
            .rst    (rst),
            .start  (go),
            .want   (want_all[gm]),
            .clk_en (mod_clk_en[gm]),
            .lrst   (mod_rst[gm]),
            .cur    (cur_all[gm]),
            .active (active[gm])
        );
    end

endmodule

// File: rtl/pwr_mod_ctrl_chk.sv
module pwr_mod_ctrl_chk
    import pwr_mod_pkg::*;
#(
    parameter int N_MODS = 32
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        busy,
    input logic [N_MODS-1:0]           clk_en,
    input logic [N_MODS-1:0]           lrst,
    input logic [N_MODS-1:0][ST_W-1:0] cur_all
);
    for (genvar gc = 0; gc < N_MODS; gc++) begin : g_chk
        // R6
        rst_release_clocked_chk: assert property (@(posedge clk) disable iff (rst)
            $fell(lrst[gc]) |-> clk_en[gc]);

        // R6
        stop_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
            ($fell(clk_en[gc]) && lrst[gc]) |-> $past(lrst[gc]));

        // R7
        move_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
            (!$stable(clk_en[gc]) || !$stable(lrst[gc])) |-> busy);

        // R5
        idle_coherent_chk: assert property (@(posedge clk) disable iff (rst)
            !busy |-> ((clk_en[gc] == cur_all[gc][0]) && (lrst[gc] == !cur_all[gc][1])));

        // R10
        cur_legal_chk: assert property (@(posedge clk) disable iff (rst)
            cur_all[gc] < 5'd4);
    end
endmodule

bind pwr_mod_ctrl pwr_mod_ctrl_chk #(.N_MODS(N_MODS)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .busy    (xfer_busy),
    .clk_en  (mod_clk_en),
    .lrst    (mod_rst),
    .cur_all (cur_all)
);

// File: tb/pwr_mod_ctrl_tb.sv
module pwr_mod_ctrl_tb;
    localparam int N = 4;
    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] mod_clk_en;
    logic [N-1:0] mod_rst;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwr_mod_ctrl #(.N_MODS(N), .STEP_CYC(S)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mod_clk_en(mod_clk_en), .mod_rst(mod_rst)
    );

    function automatic logic [11:0] a_ctrl(int m); return 12'hA00 + 12'(4*m); endfunction
    function automatic logic [11:0] a_cur(int m);  return 12'h800 + 12'(4*m); endfunction
    function automatic logic e_clk(int s); return s[0]; endfunction
    function automatic logic e_rst(int s); return !s[1]; endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic settle();
        repeat (3*S + 2) @(negedge clk);
    endtask

    task automatic chk_mod(string req, int m, int s);
        logic [31:0] d;
        chk(req, {31'd0, mod_clk_en[m]}, {31'd0, e_clk(s)});
        chk(req, {31'd0, mod_rst[m]}, {31'd0, e_rst(s)});
        rd(a_cur(m), d);
        chk(req, d, 32'(s));
    endtask

    task automatic sweep_pair(int m, int fs, int ts);
        logic [31:0] d;
        logic a_clk;
        wr(a_ctrl(m), 32'(fs));
        wr(12'h120, 32'h1);
        settle();
        chk_mod("R5", m, fs);
        wr(a_ctrl(m), 32'(ts));
        // R3: recording alone leaves outputs and busy untouched
        chk_mod("R3", m, fs);
        rd(12'h128, d);
        chk("R3", d, 32'h0);
        a_clk = (e_clk(ts) || (e_rst(ts) != e_rst(fs))) ? 1'b1 : e_clk(fs);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'h120; reg_wdata = 32'h1;
        for (int k = 0; k <= 3*S; k++) begin
            logic xc, xr, xb;
            @(negedge clk);
            reg_we = 1'b0; reg_addr = 12'h128;
            #1;
            if (fs == ts) begin
                xc = e_clk(fs); xr = e_rst(fs); xb = 1'b0;
            end else begin
                xc = (k < 2*S) ? a_clk : e_clk(ts);
                xr = (k < S) ? e_rst(fs) : e_rst(ts);
                xb = (k < 3*S);
            end
            chk("R6", {31'd0, mod_clk_en[m]}, {31'd0, xc});
            chk("R6", {31'd0, mod_rst[m]}, {31'd0, xr});
            chk("R7", reg_rdata, {31'd0, xb});
        end
        rd(a_cur(m), d);
        chk("R9", d, 32'(ts));
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1
        for (int m = 0; m < N; m++) begin
            chk("R1", {31'd0, mod_clk_en[m]}, 32'h0);
            chk("R1", {31'd0, mod_rst[m]}, 32'h1);
            rd(a_ctrl(m), d); chk("R1", d, 32'h0);
            rd(a_cur(m), d);  chk("R1", d, 32'h0);
        end
        rd(12'h128, d); chk("R1", d, 32'h0);

        // R11
        rd(12'h120, d); chk("R11", d, 32'h0);
        rd(12'h124, d); chk("R11", d, 32'h0);
        rd(12'hA10, d); chk("R11", d, 32'h0);

        // R2: only the low five bits are stored
        wr(a_ctrl(2), 32'hFFFF_FFFF);
        rd(a_ctrl(2), d); chk("R2", d, 32'h1F);
        // R10: invalid wanted state moves nothing
        wr(12'h120, 32'h1);
        rd(12'h128, d); chk("R10", d, 32'h0);
        chk_mod("R10", 2, 0);
        wr(a_ctrl(2), 32'h0000_0104);
        rd(a_ctrl(2), d); chk("R2", d, 32'h04);
        wr(12'h120, 32'h1);
        settle();
        chk_mod("R10", 2, 0);
        wr(a_ctrl(2), 32'h0);

        // R4/R5/R6/R7: every from/to pair
        for (int fs = 0; fs < 4; fs++)
            for (int ts = 0; ts < 4; ts++)
                sweep_pair((fs*4 + ts) % N, fs, ts);

        // R4: several modules in one batch, each to its own target
        for (int m = 0; m < N; m++) wr(a_ctrl(m), 32'(3 - m));
        wr(12'h120, 32'h1);
        settle();
        for (int m = 0; m < N; m++) chk_mod("R4", m, 3 - m);
        // R4: command with bit 0 clear does nothing
        wr(a_ctrl(0), 32'h1);
        wr(12'h120, 32'h2);
        settle();
        chk_mod("R4", 0, 3);

        // R8: second command while busy is ignored
        wr(a_ctrl(0), 32'h2);
        wr(12'h120, 32'h1);
        wr(a_ctrl(1), 32'h0);
        wr(12'h120, 32'h1);
        settle();
        chk_mod("R8", 0, 2);
        chk_mod("R8", 1, 2);
        wr(12'h120, 32'h1);
        settle();
        chk_mod("R8", 1, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule